// File: doc/BRIEF.md
# Packed Audio Sample Unpacker

This block sits between an audio sample FIFO and a serial line encoder. It takes 64-bit words from the FIFO through a valid/ready handshake. Each word is cut into equal slots: eight 8-bit slots, four 16-bit slots or two 32-bit slots, chosen by a packing code. Every slot holds a right-justified sample. A programmable MSB index moves the sample so that its most significant bit lands on bit 23 of a 24-bit output.

A channel-mask field selects mono or stereo. In mono, each slot becomes one output pair, with the same sample on the left and the right. In stereo, two adjacent slots form one pair. Slots are used from the lowest upward. The next FIFO word is taken only when the final pair of the current word leaves the block. The output is a valid/ready stream of left/right pairs. The configuration is captured together with each word, so software may reprogram it between words without disturbing the word being drained.

Top module: `pcm_slot_unpacker`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: Packing code 0 cuts the word into eight 8-bit slots. Slot k is in_word[8k+7:8k], and slot 0 is output first.
- R3: Packing code 2 cuts the word into four 16-bit slots. Slot k is in_word[16k+15:16k], used lowest first.
- R4: Packing code 4, and each of the unused codes 1, 3, 5, 6 and 7, cuts the word into two 32-bit slots. Slot k is in_word[32k+31:32k].
- R5: Slot bit cfg_msb appears at output bit 23, and each lower slot bit follows at the next lower output bit. Output bits with no source bit below bit 0 are 0. Slot bits below output bit 0 are dropped when cfg_msb > 23. Slot bits above cfg_msb never reach the output.
- R6: When cfg_mask[1] is 0 (mono), each slot produces one output pair, and out_left equals out_right.
- R7: When cfg_mask[1] is 1 (stereo), pair j carries slot 2j on out_left and slot 2j+1 on out_right. cfg_mask bit 0 and bits 7:2 have no effect.
- R8: A word is accepted on a clock edge where in_valid and in_ready are both 1. in_ready is 1 only when no word is held, or when the final pair of the held word is taken in that same cycle (out_valid and out_ready both 1).
- R9: While out_valid is 1 and out_ready is 0, out_left and out_right stay stable and no slot is consumed.
- R10: cfg_pack, cfg_msb and cfg_mask are sampled when a word is accepted. Changing them while that word is still being drained does not change its output pairs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_word | input | 64 | Packed FIFO word |
| in_valid | input | 1 | FIFO word present |
| in_ready | output | 1 | Block takes the word on this edge |
| cfg_pack | input | 3 | Packing code (0: 8-bit, 2: 16-bit, other: 32-bit slots) |
| cfg_msb | input | 5 | Bit index of the sample MSB inside its slot |
| cfg_mask | input | 8 | Channel mask; bit 1 selects stereo |
| out_valid | output | 1 | Output pair present |
| out_ready | input | 1 | Consumer takes the pair on this edge |
| out_left | output | 24 | Left sample, MSB at bit 23 |
| out_right | output | 24 | Right sample, MSB at bit 23 |

## Verification
The hardest case to reach is the cycle where the final pair of one word leaves and the next word is taken on the same edge. A stall has to be held across that boundary as well, because in_ready must stay low on every earlier pair.

The directed tests reach this case in three steps. They keep in_valid high with a second word waiting. They hold out_ready low for several cycles on the first pair of a two-slot word. They then release out_ready, and in_ready must rise only on the last pair.

A separate test changes every configuration input in the middle of a word. It shows that the captured settings, not the live pins, decide the remaining pairs.

// File: rtl/unpack_pkg.sv
package unpack_pkg;

  localparam int SLOT_MAX_W = 32;
  localparam int TYPE_W     = 3;

  typedef enum logic [1:0] {
    PK_B8  = 2'd0,
    PK_B16 = 2'd1,
    PK_B32 = 2'd2
  } pack_e;

  // Unlisted codes fall back to the widest packing.
  function automatic pack_e decode_pack(input logic [TYPE_W-1:0] code);
    case (code)
      3'd0:    return PK_B8;
      3'd2:    return PK_B16;
      default: return PK_B32;
    endcase
  endfunction

  function automatic int slot_width(input pack_e p);
    case (p)
      PK_B8:   return 8;
      PK_B16:  return 16;
      default: return 32;
    endcase
  endfunction

  function automatic int slots_in_word(input pack_e p, input int word_w);
    return word_w / slot_width(p);
  endfunction

endpackage

// File: rtl/unpack_ctrl.sv
module unpack_ctrl
  import unpack_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int MSB_W  = 5,
  parameter int IDX_W  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [WORD_W-1:0]    in_word,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [TYPE_W-1:0]    in_type,
  input  logic [MSB_W-1:0]     in_msb,
  input  logic                 in_stereo,
  input  logic                 out_ready,
  output logic                 have_q,
  output logic [WORD_W-1:0]    word_q,
  output pack_e                pack_q,
  output logic [MSB_W-1:0]     msb_q,
  output logic                 stereo_q,
  output logic [IDX_W-1:0]     idx_q,
  output logic                 last
);

  logic [IDX_W:0] nslots;
  logic [IDX_W:0] step;
  logic [IDX_W:0] next_idx;
  logic           accept;
  logic           pop;

  assign nslots   = (IDX_W+1)'(slots_in_word(pack_q, WORD_W));
  assign step     = stereo_q ? (IDX_W+1)'(2) : (IDX_W+1)'(1);
  assign next_idx = {1'b0, idx_q} + step;
  assign last     = (next_idx >= nslots);
  assign pop      = have_q && out_ready;
  assign in_ready = !have_q || (out_ready && last);
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q   <= 1'b0;
      word_q   <= '0;
      pack_q   <= PK_B32;
      msb_q    <= '0;
      stereo_q <= 1'b0;
      idx_q    <= '0;
    end else if (accept) begin
      have_q   <= 1'b1;
      word_q   <= in_word;
      pack_q   <= decode_pack(in_type);
      msb_q    <= in_msb;
      stereo_q <= in_stereo;
      idx_q    <= '0;
    end else if (pop) begin
      if (last) have_q <= 1'b0;
      else      idx_q  <= next_idx[IDX_W-1:0];
    end
  end

  // Pairs emitted since the current word arrived, kept only for checking.
  logic [IDX_W:0] pops_since;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pops_since <= '0;
    else if (accept) pops_since <= '0;
    else if (pop)    pops_since <= pops_since + 1'b1;
  end

  AST_WORD_FULLY_USED: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && last) |-> ((pops_since + 1'b1) == (nslots >> stereo_q))); // R8

  AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    have_q |-> ({1'b0, idx_q} < nslots)); // R4

  AST_FIRST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (have_q && idx_q == '0)); // R2

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (have_q && !out_ready) |=> (have_q && $stable(idx_q) && $stable(word_q))); // R9

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (have_q && !accept) |=> ($stable(pack_q) && $stable(msb_q) && $stable(stereo_q))); // R10

endmodule

// File: rtl/unpack_slot_sel.sv
module unpack_slot_sel
  import unpack_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int IDX_W  = 3
) (
  input  logic [WORD_W-1:0]     word,
  input  pack_e                 pk,
  input  logic [IDX_W-1:0]      idx,
  output logic [SLOT_MAX_W-1:0] slot
);

  localparam int N8    = WORD_W / 8;
  localparam int N16   = WORD_W / 16;
  localparam int N32   = WORD_W / 32;
  localparam int I16_W = (N16 > 1) ? $clog2(N16) : 1;
  localparam int I32_W = (N32 > 1) ? $clog2(N32) : 1;

  logic [7:0]  s8  [N8];
  logic [15:0] s16 [N16];
  logic [31:0] s32 [N32];

  for (genvar g = 0; g < N8; g++) begin : g_s8
    assign s8[g] = word[g*8 +: 8];
  end
  for (genvar g = 0; g < N16; g++) begin : g_s16
    assign s16[g] = word[g*16 +: 16];
  end
  for (genvar g = 0; g < N32; g++) begin : g_s32
    assign s32[g] = word[g*32 +: 32];
  end

  always_comb begin
    case (pk)
      PK_B8:   slot = SLOT_MAX_W'(s8[idx]);
      PK_B16:  slot = SLOT_MAX_W'(s16[idx[I16_W-1:0]]);
      default: slot = SLOT_MAX_W'(s32[idx[I32_W-1:0]]);
    endcase
  end

endmodule

// File: rtl/unpack_align.sv
module unpack_align #(
  parameter int SLOT_W = 32,
  parameter int MSB_W  = 5,
  parameter int OUT_W  = 24
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic [MSB_W-1:0]  msb,
  output logic [OUT_W-1:0]  aligned
);

  localparam int EXT_W = SLOT_W + OUT_W - 1;

  // Pre-shift so that slot bit 0 sits at OUT_W-1. A right shift by msb then
  // moves slot bit msb to the output MSB. Higher bits fall off the top and
  // lower bits fall off the bottom.
  function automatic logic [OUT_W-1:0] place_msb(input logic [SLOT_W-1:0] s,
                                                  input logic [MSB_W-1:0]  m);
    logic [EXT_W-1:0] ext;
    ext = {s, {(OUT_W-1){1'b0}}} >> m;
    return ext[OUT_W-1:0];
  endfunction

  assign aligned = place_msb(slot, msb);

endmodule

// File: rtl/pcm_slot_unpacker.sv
module pcm_slot_unpacker
  import unpack_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int OUT_W  = 24,
  parameter int MSB_W  = 5,
  parameter int MASK_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [WORD_W-1:0]    in_word,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [TYPE_W-1:0]    cfg_pack,
  input  logic [MSB_W-1:0]     cfg_msb,
  input  logic [MASK_W-1:0]    cfg_mask,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [OUT_W-1:0]     out_left,
  output logic [OUT_W-1:0]     out_right
);

  localparam int IDX_W = $clog2(WORD_W / 8);

  logic              have_q;
  logic [WORD_W-1:0] word_q;
  pack_e             pack_q;
  logic [MSB_W-1:0]  msb_q;
  logic              stereo_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  idx_r;
  logic              last;
  logic [SLOT_MAX_W-1:0] slot_l, slot_r;

  // Only bit 1 of the mask decides the channel layout.
  logic unused_mask;
  assign unused_mask = ^{cfg_mask[MASK_W-1:2], cfg_mask[0]};

  unpack_ctrl #(.WORD_W(WORD_W), .MSB_W(MSB_W), .IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_word   (in_word),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_type   (cfg_pack),
    .in_msb    (cfg_msb),
    .in_stereo (cfg_mask[1]),
    .out_ready (out_ready),
    .have_q    (have_q),
    .word_q    (word_q),
    .pack_q    (pack_q),
    .msb_q     (msb_q),
    .stereo_q  (stereo_q),
    .idx_q     (idx_q),
    .last      (last)
  );

  assign idx_r = stereo_q ? (idx_q + 1'b1) : idx_q;

  unpack_slot_sel #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_sel_l (
    .word (word_q), .pk (pack_q), .idx (idx_q), .slot (slot_l)
  );
  unpack_slot_sel #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_sel_r (
    .word (word_q), .pk (pack_q), .idx (idx_r), .slot (slot_r)
  );

  unpack_align #(.SLOT_W(SLOT_MAX_W), .MSB_W(MSB_W), .OUT_W(OUT_W)) u_align_l (
    .slot (slot_l), .msb (msb_q), .aligned (out_left)
  );
  unpack_align #(.SLOT_W(SLOT_MAX_W), .MSB_W(MSB_W), .OUT_W(OUT_W)) u_align_r (
    .slot (slot_r), .msb (msb_q), .aligned (out_right)
  );

  assign out_valid = have_q;

  // Output bits below the shifted sample must be zero.
  logic [OUT_W-1:0] low_fill;
  always_comb begin
    if (int'(msb_q) < OUT_W - 1)
      low_fill = (OUT_W'(1) << (OUT_W - 1 - int'(msb_q))) - OUT_W'(1);
    else
      low_fill = '0;
  end

  AST_MONO_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !stereo_q) |-> (out_left == out_right)); // R6

  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (((out_left | out_right) & low_fill) == '0)); // R5

endmodule

// File: tb/pcm_slot_unpacker_bench.sv
module pcm_slot_unpacker_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] in_word = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  cfg_pack = '0;
  logic [4:0]  cfg_msb = '0;
  logic [7:0]  cfg_mask = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] out_left, out_right;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Settings of the word the bench expects to see drained.
  logic [63:0] hw;
  logic [2:0]  ht;
  logic [4:0]  hm;
  logic [7:0]  hk;

  always #5 clk = ~clk;

  pcm_slot_unpacker u_pcm_slot_unpacker (
    .clk (clk), .rst_n (rst_n), .in_word (in_word), .in_valid (in_valid),
    .in_ready (in_ready), .cfg_pack (cfg_pack), .cfg_msb (cfg_msb),
    .cfg_mask (cfg_mask), .out_valid (out_valid), .out_ready (out_ready),
    .out_left (out_left), .out_right (out_right)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int wd_of(input logic [2:0] t);
    if (t == 3'd0) return 8;
    if (t == 3'd2) return 16;
    return 32;
  endfunction

  // Bit by bit: output bit b takes slot bit (m - 23 + b) when it exists.
  function automatic logic [23:0] model(input logic [63:0] w, input logic [2:0] t,
                                        input logic [4:0] m, input int k);
    logic [23:0] r;
    int wd;
    wd = wd_of(t);
    r = '0;
    for (int b = 0; b < 24; b++) begin
      int src;
      src = int'(m) - 23 + b;
      if (src >= 0 && src < wd) r[b] = w[k*wd + src];
    end
    return r;
  endfunction

  task automatic push(input logic [63:0] w, input logic [2:0] t,
                      input logic [4:0] m, input logic [7:0] k);
    @(negedge clk);
    in_word = w; cfg_pack = t; cfg_msb = m; cfg_mask = k; in_valid = 1'b1;
    hw = w; ht = t; hm = m; hk = k;
    #1 chk(in_ready == 1'b1, "R8 idle ready", 64'(in_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Called at a negedge with the first pair of the held word on the outputs.
  task automatic drain(input string tag);
    int nout;
    bit st;
    st = hk[1];
    nout = (64 / wd_of(ht)) / (st ? 2 : 1);
    for (int j = 0; j < nout; j++) begin
      int kl, kr;
      kl = st ? 2*j : j;
      kr = st ? 2*j + 1 : j;
      #1;
      chk(out_valid == 1'b1, {tag, " valid"}, 64'(out_valid), 64'd1);
      chk(out_left == model(hw, ht, hm, kl), {tag, " left"},
          64'(out_left), 64'(model(hw, ht, hm, kl)));
      chk(out_right == model(hw, ht, hm, kr), {tag, " right"},
          64'(out_right), 64'(model(hw, ht, hm, kr)));
      chk(in_ready == (j == nout - 1), {tag, " R8 ready"},
          64'(in_ready), 64'(j == nout - 1));
      @(negedge clk);
    end
    #1 chk(out_valid == 1'b0, {tag, " R8 empty"}, 64'(out_valid), 64'd0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R1 in_ready", 64'(in_ready), 64'd1);
  endtask

  task automatic t_b8_mono;
    push(64'h8877_6655_4433_2211, 3'd0, 5'd7, 8'h01);
    drain("R2 R5 R6 byte mono");
  endtask

  task automatic t_b16_stereo;
    push(64'hDEAD_BEEF_1234_5678, 3'd2, 5'd15, 8'h03);
    drain("R3 R7 half stereo");
  endtask

  task automatic t_b32_24bit;
    push(64'hCD89_ABCD_AB12_3456, 3'd4, 5'd23, 8'h03);
    drain("R4 R5 word 24bit");
  endtask

  task automatic t_unused_codes;
    logic [2:0] codes [5] = '{3'd1, 3'd3, 3'd5, 3'd6, 3'd7};
    foreach (codes[i]) begin
      push(64'h0123_4567_89AB_CDEF, codes[i], 5'd31, 8'h01);
      drain("R4 R5 unused code truncate");
    end
  endtask

  task automatic t_narrow;
    push(64'h0FFF_0800_0123_0ABC, 3'd2, 5'd11, 8'h01);
    drain("R5 12bit zero fill");
  endtask

  task automatic t_mask_bits;
    push(64'hA1B2_C3D4_E5F6_0718, 3'd0, 5'd7, 8'hF1);
    drain("R7 mask F1 mono");
    push(64'hA1B2_C3D4_E5F6_0718, 3'd0, 5'd7, 8'hF2);
    drain("R7 mask F2 stereo");
    push(64'h1020_3040_5060_7080, 3'd2, 5'd15, 8'h00);
    drain("R6 mask 00 mono");
  endtask

  task automatic t_stall;
    logic [23:0] l0, r0;
    push(64'h1111_2222_3333_4444, 3'd4, 5'd23, 8'h01);
    out_ready = 1'b0;
    in_word = 64'h5555_6666_7777_8888;
    in_valid = 1'b1;
    #1;
    l0 = out_left;
    r0 = out_right;
    chk(l0 == model(hw, ht, hm, 0), "R9 first pair", 64'(l0), 64'(model(hw, ht, hm, 0)));
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      #1;
      chk(out_valid == 1'b1, "R9 stall valid", 64'(out_valid), 64'd1);
      chk(out_left == l0 && out_right == r0, "R9 stall stable",
          64'({out_left, out_right}), 64'({l0, r0}));
      chk(in_ready == 1'b0, "R8 no fetch on stall", 64'(in_ready), 64'd0);
    end
    out_ready = 1'b1;
    #1 chk(in_ready == 1'b0, "R8 not last slot", 64'(in_ready), 64'd0);
    @(negedge clk);
    #1;
    chk(out_left == model(hw, ht, hm, 1), "R9 advance after stall",
        64'(out_left), 64'(model(hw, ht, hm, 1)));
    chk(in_ready == 1'b1, "R8 ready on last slot", 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    hw = 64'h5555_6666_7777_8888;
    drain("R8 R9 word after stall");
  endtask

  task automatic t_cfg_change;
    push(64'h0F1E_2D3C_4B5A_6978, 3'd0, 5'd7, 8'h03);
    cfg_pack = 3'd4;
    cfg_msb  = 5'd31;
    cfg_mask = 8'h01;
    drain("R10 config changed mid word");
  endtask

  task automatic t_back_to_back;
    push(64'hAAAA_5555_0F0F_F0F0, 3'd4, 5'd23, 8'h03);
    in_word = 64'h0102_0304_0506_0708;
    in_valid = 1'b1;
    #1;
    chk(out_left == model(hw, ht, hm, 0), "R8 b2b first word",
        64'(out_left), 64'(model(hw, ht, hm, 0)));
    chk(in_ready == 1'b1, "R8 b2b ready", 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    hw = 64'h0102_0304_0506_0708;
    drain("R8 b2b second word");
  endtask

  initial begin
    t_reset();
    t_b8_mono();
    t_b16_stereo();
    t_b32_24bit();
    t_unused_codes();
    t_narrow();
    t_mask_bits();
    t_stall();
    t_cfg_change();
    t_back_to_back();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule